// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key Queue

This block walks a key matrix of up to eight columns by eight rows. It steps a 3-bit column index at a fixed division of the clock and drives it on an 8-bit scan bus. The bus carries either the plain binary index, for an external decoder, or an active-low one-hot pattern. At the end of each column slot it samples the return lines, on which a pressed key reads low. It applies a two-scan debounce and 2-key lockout, then turns each accepted key into a 6-bit code.

Accepted codes go into an eight-entry first-in first-out queue. The host polls the entry count and a sticky overrun flag, reads the head code and pops it. The host also has an interrupt line that rises when a code arrives, plus two clear strobes: one for the interrupt and one for the whole queue.

Top module: `kbd_scan_top`

## Requirements
- R1: Parameters NCOLS and NROWS (each 2 to 8) set the matrix size. The column index runs 0 to NCOLS-1 and wraps to 0. Return lines with an index of NROWS or above never cause a code.
- R2: After reset the column index is 0. It advances once every TICK_DIV clocks, and the first advance happens on the TICK_DIV-th clock edge after reset. The return lines are sampled on the same edge that ends the column's slot.
- R3: With scan_decoded=0, scan_out = {5'b0, column}. With scan_decoded=1, scan_out is all ones except bit [column], which is 0.
- R4: A return line at 0 means pressed. A key produces a code only when it is seen pressed on two consecutive samples of its column.
- R5: The code is {column[2:0], row[2:0]}. When several keys in one column qualify on the same sample, the lowest row wins.
- R6: Once a key is accepted, no other code is produced until a sample of that key's column shows it released. A key that is still held is never repeated. A different key that is still held when the lock frees is accepted at its column's next sample.
- R7: Codes are queued first in, first out, up to 8 entries. key_code shows the head entry, or 0 when the queue is empty. fifo_count gives the number of entries. A host_pop pulse removes the head and is ignored when the queue is empty.
- R8: A code that arrives while the queue is full is dropped and sets fifo_ovr. fifo_ovr stays set until host_clr_fifo.
- R9: irq rises on the edge that stores a code. It falls on host_clr_irq, or when a pop leaves the queue empty. A store in the same cycle overrides both.
- R10: host_clr_fifo empties the queue and clears fifo_ovr and irq. A code arriving in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_decoded | input | 1 | 0: binary scan code, 1: active-low one-hot scan |
| scan_out | output | 8 | Column drive bus |
| ret_n | input | 8 | Return lines, low when a key is pressed |
| host_pop | input | 1 | Remove the head code |
| host_clr_irq | input | 1 | Clear the interrupt request |
| host_clr_fifo | input | 1 | Empty the queue and clear its flags |
| key_code | output | 6 | Head code {column, row} |
| fifo_count | output | $clog2(FIFO_DEPTH+1) | Number of queued codes |
| fifo_ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives bouncy presses and presses shorter than one scan. A debounce that counts single samples would queue codes for these. It holds a second key during a lockout and then releases the first. A lock that never frees would lose the second key, and one that ignores the owner would queue both at once. It presses two rows of one column together to expose a wrong row priority. It holds a key on a row above NROWS to catch a row mask that is missing. It fills the queue past eight entries to catch an overwrite instead of a drop. It clears the interrupt while data remains, drains the queue with pops, and then clears a queue that is not empty.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int IDX_W  = 3;
  localparam int CODE_W = 2 * IDX_W;

  typedef logic [CODE_W-1:0] key_code_t;

  function automatic key_code_t make_code(input logic [IDX_W-1:0] col,
                                          input logic [IDX_W-1:0] row);
    return {col, row};
  endfunction

  function automatic logic [IDX_W-1:0] step_col(input logic [IDX_W-1:0] col,
                                                input int unsigned ncols);
    return (32'(col) == ncols - 1) ? '0 : col + 1'b1;
  endfunction

  function automatic logic [7:0] drive_pattern(input logic [IDX_W-1:0] col,
                                               input logic decoded);
    return decoded ? ~(8'b1 << col) : {5'b0, col};
  endfunction

  function automatic logic [IDX_W-1:0] lowest_row(input logic [7:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/kbd_scan_ctr.sv
module kbd_scan_ctr
  import kbd_pkg::*;
#(
  parameter int NCOLS    = 8,
  parameter int TICK_DIV = 640
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decoded,
  output logic [IDX_W-1:0] col,
  output logic             tick,
  output logic [7:0]       scan_out
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] div_cnt;

  assign tick     = (div_cnt == DIV_W'(TICK_DIV - 1));
  assign scan_out = drive_pattern(col, decoded);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      col     <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) col <= step_col(col, NCOLS);
    end
  end

  p_col_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(col) < NCOLS);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(col));
  p_onehot_scan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    decoded |-> $countones(~scan_out) == 1);
endmodule

// File: rtl/kbd_lockout.sv
module kbd_lockout
  import kbd_pkg::*;
#(
  parameter int NCOLS = 8,
  parameter int NROWS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [IDX_W-1:0] col,
  input  logic [7:0]       ret_n,
  output logic             push,
  output key_code_t        push_code
);
  localparam logic [7:0] ROW_MASK = 8'((1 << NROWS) - 1);

  logic [NCOLS-1:0][7:0] prev;
  logic [7:0]            now_pressed, qualified;
  logic                  owner_valid, release_ev;
  logic [IDX_W-1:0]      owner_col, owner_row;

  assign now_pressed = ~ret_n & ROW_MASK;
  assign qualified   = now_pressed & prev[col];
  assign push        = tick && !owner_valid && (|qualified);
  assign push_code   = make_code(col, lowest_row(qualified));
  assign release_ev  = tick && owner_valid && (owner_col == col) &&
                       !now_pressed[owner_row];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev        <= '0;
      owner_valid <= 1'b0;
      owner_col   <= '0;
      owner_row   <= '0;
    end else begin
      if (tick) prev[col] <= now_pressed;
      if (push) begin
        owner_valid <= 1'b1;
        owner_col   <= col;
        owner_row   <= lowest_row(qualified);
      end else if (release_ev) begin
        owner_valid <= 1'b0;
      end
    end
  end

  p_release_on_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(owner_valid) |-> $past(tick));
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo
  import kbd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  key_code_t                    din,
  input  logic                         pop,
  output key_code_t                    head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         push_ok,
  output logic                         pop_ok,
  output logic                         ovr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  key_code_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (push && full) ovr <= 1'b1;
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr |=> ovr);
endmodule

// File: rtl/kbd_scan_top.sv
module kbd_scan_top
  import kbd_pkg::*;
#(
  parameter int NCOLS      = 8,
  parameter int NROWS      = 8,
  parameter int TICK_DIV   = 640,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              scan_decoded,
  output logic [7:0]                        scan_out,
  input  logic [7:0]                        ret_n,
  input  logic                              host_pop,
  input  logic                              host_clr_irq,
  input  logic                              host_clr_fifo,
  output logic [CODE_W-1:0]                 key_code,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_count,
  output logic                              fifo_ovr,
  output logic                              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             tick, push, push_ok, pop_ok;
  logic [IDX_W-1:0] col;
  key_code_t        push_code, head;

  kbd_scan_ctr #(.NCOLS(NCOLS), .TICK_DIV(TICK_DIV)) u_scan (
    .clk(clk), .rst_n(rst_n), .decoded(scan_decoded),
    .col(col), .tick(tick), .scan_out(scan_out)
  );

  kbd_lockout #(.NCOLS(NCOLS), .NROWS(NROWS)) u_lock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .col(col), .ret_n(ret_n),
    .push(push), .push_code(push_code)
  );

  kbd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(host_clr_fifo), .push(push),
    .din(push_code), .pop(host_pop), .head(head), .count(fifo_count),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovr(fifo_ovr)
  );

  assign key_code = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   irq <= 1'b0;
    else if (host_clr_fifo)                       irq <= 1'b0;
    else if (push_ok)                             irq <= 1'b1;
    else if (host_clr_irq)                        irq <= 1'b0;
    else if (pop_ok && fifo_count == CNT_W'(1))   irq <= 1'b0;
  end

  p_irq_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fifo_count != '0);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr_fifo |=> fifo_count == '0 && !irq && !fifo_ovr);
endmodule

// File: tb/kbd_scan_top_tb.sv
module kbd_scan_top_tb_top;
  localparam int NC = 5;
  localparam int NR = 6;
  localparam int TD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_decoded = 1'b0;
  logic host_pop = 1'b0, host_clr_irq = 1'b0, host_clr_fifo = 1'b0;
  logic [7:0] scan_out, ret_n;
  logic [5:0] key_code;
  logic [3:0] fifo_count;
  logic fifo_ovr, irq;

  always #2 clk = ~clk;

  kbd_scan_top #(.NCOLS(NC), .NROWS(NR), .TICK_DIV(TD), .FIFO_DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_decoded(scan_decoded), .scan_out(scan_out),
    .ret_n(ret_n), .host_pop(host_pop), .host_clr_irq(host_clr_irq),
    .host_clr_fifo(host_clr_fifo), .key_code(key_code), .fifo_count(fifo_count),
    .fifo_ovr(fifo_ovr), .irq(irq)
  );

  // key matrix: keys[c][r] = 1 when held; return lines follow the bench's column
  logic [7:0] keys [8];
  int m_col = 0;
  assign ret_n = ~keys[m_col];

  // behavioural reference
  int m_div = 0;
  logic [7:0] m_prev [8];
  bit m_own = 0;
  int m_own_c = 0, m_own_r = 0;
  int q[$];
  bit m_ovr = 0, m_irq = 0;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit tick, push;
    int pcode, was;
    logic [7:0] now;
    tick = (m_div == TD - 1);
    push = 0; pcode = 0;
    if (tick) begin
      now = 8'h00;
      for (int r = 0; r < NR; r++) now[r] = !ret_n[r];
      if (!m_own) begin
        for (int r = NR - 1; r >= 0; r--)
          if (now[r] && m_prev[m_col][r]) begin
            push = 1; pcode = m_col * 8 + r; m_own_c = m_col; m_own_r = r;
          end
        if (push) m_own = 1;
      end else if (m_own_c == m_col && !now[m_own_r]) begin
        m_own = 0;
      end
      m_prev[m_col] = now;
      m_col = (m_col == NC - 1) ? 0 : m_col + 1;
    end
    m_div = tick ? 0 : m_div + 1;
    was = q.size();
    if (host_clr_fifo) begin
      q.delete(); m_ovr = 0; m_irq = 0;
    end else begin
      bit pop_ok, push_ok;
      pop_ok  = host_pop && was > 0;
      push_ok = push && was < 8;
      if (push && was >= 8) m_ovr = 1;
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back(pcode);
      if (push_ok) m_irq = 1;
      else if (host_clr_irq) m_irq = 0;
      else if (pop_ok && was == 1) m_irq = 0;
    end
  endtask

  task automatic compare();
    int exp_scan;
    exp_scan = scan_decoded ? (~(1 << m_col)) & 8'hFF : m_col;
    check("R2/R3 scan_out", int'(scan_out), exp_scan);
    check("R5 key_code", int'(key_code), q.size() > 0 ? q[0] : 0);
    check("R7 fifo_count", int'(fifo_count), q.size());
    check("R8 fifo_ovr", int'(fifo_ovr), int'(m_ovr));
    check("R9 irq", int'(irq), int'(m_irq));
  endtask

  task automatic cycle();
    @(posedge clk); #1;
    model_step();
    compare();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic pulse_pop();
    host_pop = 1; cycle(); host_pop = 0;
  endtask

  task automatic tap(int c, int r, int hold, int gap);
    keys[c][r] = 1'b1; run(hold);
    keys[c][r] = 1'b0; run(gap);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin keys[c] = 8'h00; m_prev[c] = 8'h00; end
    repeat (3) @(negedge clk);
    check("R2 reset scan_out", int'(scan_out), 0);
    check("R7 reset count", int'(fifo_count), 0);
    check("R9 reset irq", int'(irq), 0);
    check("R8 reset ovr", int'(fifo_ovr), 0);
    rst_n = 1'b1;

    run(30);                                   // R1 R2 R3 binary walk
    scan_decoded = 1'b1; run(30);              // R3 one-hot walk

    keys[1][2] = 1'b1; run(8); keys[1][2] = 1'b0; run(60);
    check("R4 short press ignored", int'(fifo_count), 0);

    for (int i = 0; i < 6; i++) begin keys[3][4] = ~keys[3][4]; run(3); end
    keys[3][4] = 1'b1; run(80);
    check("R4 debounced press count", int'(fifo_count), 1);
    check("R5 code col3 row4", int'(key_code), 28);
    check("R9 irq after store", int'(irq), 1);

    keys[0][1] = 1'b1; run(80);
    check("R6 lockout blocks second key", int'(fifo_count), 1);
    keys[3][4] = 1'b0; run(60);
    check("R6 second key after release", int'(fifo_count), 2);
    pulse_pop();
    check("R7 head after pop", int'(key_code), 1);
    keys[0][1] = 1'b0; run(60);

    keys[2][5] = 1'b1; keys[2][3] = 1'b1; run(80);
    check("R5 lowest row wins", int'(fifo_count), 2);
    pulse_pop();
    check("R5 code col2 row3", int'(key_code), 19);
    keys[2][5] = 1'b0; keys[2][3] = 1'b0; run(60);

    keys[1][7] = 1'b1; run(80); keys[1][7] = 1'b0;
    check("R1 row above NROWS ignored", int'(fifo_count), 1);

    host_clr_irq = 1; cycle(); host_clr_irq = 0;
    check("R9 irq cleared by host", int'(irq), 0);
    check("R9 data kept after irq clear", int'(fifo_count), 1);

    pulse_pop();
    for (int i = 0; i < 9; i++) tap(i % NC, (i + 1) % NR, 50, 50);
    check("R8 queue full", int'(fifo_count), 8);
    check("R8 overrun set", int'(fifo_ovr), 1);
    for (int i = 0; i < 8; i++) pulse_pop();   // order checked every cycle (R7)
    check("R9 irq low when drained", int'(irq), 0);
    check("R8 overrun sticky", int'(fifo_ovr), 1);
    pulse_pop();
    check("R7 pop on empty ignored", int'(fifo_count), 0);

    tap(4, 0, 50, 50); tap(0, 5, 50, 50);
    check("R10 before clear", int'(fifo_count), 2);
    host_clr_fifo = 1; cycle(); host_clr_fifo = 0;
    check("R10 count cleared", int'(fifo_count), 0);
    check("R10 ovr cleared", int'(fifo_ovr), 0);
    check("R10 irq cleared", int'(irq), 0);

    scan_decoded = 1'b0; run(25);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule